// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block is a one-bit-wide, read-only configuration store that an FPGA reads in master serial mode. The FPGA supplies the clock. The block holds a bit image of parameterised depth and an internal read pointer. On each qualified rising clock edge it presents the next bit of the image on a single serial output. The data path stands in for a tri-state pin: there is a data bit and a separate drive-enable flag. When the enable is low, the line counts as floating.

A combined reset/output-enable pin clears the pointer. Its polarity is fixed by a parameter. An active-low chip enable puts the device into standby.

Several devices can be chained to hold a longer image. The chip-enable output of one device feeds the chip enable of the next, and their data lines are merged. Once a device has given out its last bit, it stops driving, and its chip-enable output goes low so that the next device takes over on the same clock.

Top module: `serial_cfg_rom`

## Requirements
- R1: While the reset/output-enable pin is at its reset level, the following hold: the read pointer is zero, the past-end flag is clear, `dout_en` is 0 and `ce_out_n` is 1.
- R2: With `RST_ACTIVE_HIGH` = 1, a high level on `rst_oe` is the reset state. With `RST_ACTIVE_HIGH` = 0, a low level is the reset state. The other level enables the output.
- R3: Bits are read in ascending order starting at image bit 0. `dout` shows `rom_image[pointer]` without a clock delay. The pointer advances by one on a rising clock edge only when `ce_n` is 0 and the output is enabled.
- R4: While `ce_n` is 1, `dout_en` is 0 and the pointer holds its value. Reading resumes with the next unread bit once `ce_n` returns to 0.
- R5: `dout_en` is 1 only when `ce_n` is 0, the output is enabled and the last bit has not yet been passed.
- R6: The qualified clock edge that follows the presentation of bit `DEPTH-1` sets a sticky past-end flag. From then on, `dout_en` is 0 and the pointer stays at `DEPTH-1` with no wrap, however many further edges arrive.
- R7: While the past-end flag is set and the output is enabled, `ce_out_n` follows `ce_n`. Before the flag is set, `ce_out_n` is 1.
- R8: The past-end flag is cleared only by the reset state of `rst_oe`. While `rst_oe` is in that state, `ce_out_n` stays 1.
- R9: When two devices are chained, exactly one drives the merged line in each read cycle until both are exhausted. The merged stream is the first image followed by the second, with no gap and no overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock from the configuring FPGA; rising edge advances the pointer |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| rst_oe | input | 1 | Combined reset/output enable; reset level set by `RST_ACTIVE_HIGH` |
| rom_image | input | DEPTH | Stored image; bit i is read i-th |
| dout | output | 1 | Serial data bit, meaningful while `dout_en` is 1 |
| dout_en | output | 1 | Drive enable standing in for the tri-state control |
| ce_out_n | output | 1 | Chip enable for the next device in the chain, active low |

## Verification
The assertions assume three things about the inputs. `ce_n` and `rst_oe` change only away from the rising clock edge. `rom_image` is held constant while a read is in progress. The reset level of `rst_oe` is applied at least once before the outputs are relied on.

The bench meets these assumptions as follows. It changes every input on the falling edge and samples shortly after it. It loads a new image only while reset is held, and it starts every sweep with a reset pulse.

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int DEPTH           = 64,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             ce_n,
  input  logic             rst_oe,
  input  logic [DEPTH-1:0] rom_image,
  output logic             dout,
  output logic             dout_en,
  output logic             ce_out_n
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          reset_act;
  logic          oe_act;
  logic          step;
  logic [AW-1:0] addr;
  logic          past_tc;

  assign reset_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;
  assign oe_act    = ~reset_act;
  assign step      = ~ce_n & oe_act;

  always_ff @(posedge clk or posedge reset_act) begin
    if (reset_act) begin
      addr    <= '0;
      past_tc <= 1'b0;
    end else if (step && !past_tc) begin
      if (addr == LAST) past_tc <= 1'b1;
      else              addr    <= addr + 1'b1;
    end
  end

  assign dout_en  = step & ~past_tc;
  assign dout     = dout_en & rom_image[addr];
  assign ce_out_n = ~(step & past_tc);

endmodule

// File: rtl/serial_cfg_rom_chk.sv
module serial_cfg_rom_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          ce_n,
  input logic          reset_act,
  input logic [AW-1:0] addr,
  input logic          past_tc,
  input logic          dout_en,
  input logic          ce_out_n
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_RESET_STATE: assert property (@(negedge clk)
    reset_act |-> (addr == '0 && !past_tc && !dout_en && ce_out_n)); // R1

  AST_ADVANCE: assert property (@(posedge clk) disable iff (reset_act)
    (!reset_act && !ce_n && !past_tc && addr != LAST) |=> addr == $past(addr) + 1'b1); // R3

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (reset_act)
    ce_n |=> $stable(addr) && $stable(past_tc)); // R4

  AST_TC_EDGE: assert property (@(posedge clk) disable iff (reset_act)
    (!reset_act && !ce_n && addr == LAST) |=> past_tc); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (reset_act)
    past_tc |=> past_tc && addr == LAST); // R6

  AST_ONE_ROLE: assert property (@(negedge clk) disable iff (reset_act)
    !(dout_en && !ce_out_n)); // R5

  AST_CEO_IDLE: assert property (@(negedge clk) disable iff (reset_act)
    !past_tc |-> ce_out_n); // R7

endmodule

bind serial_cfg_rom serial_cfg_rom_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .ce_n     (ce_n),
  .reset_act(reset_act),
  .addr     (addr),
  .past_tc  (past_tc),
  .dout_en  (dout_en),
  .ce_out_n (ce_out_n)
);

// File: tb/tb_serial_cfg_rom.sv
`timescale 1ns/100ps
module tb_serial_cfg_rom;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ce0_n = 1'b1;
  logic [D-1:0] img_a = '0;
  logic [D-1:0] img_b = '0;
  logic rst_h;
  logic d0, e0, co0, d1, e1, co1, dh, eh, coh;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign rst_h = ~rst_n;

  serial_cfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0)) dut (
    .clk(clk), .ce_n(ce0_n), .rst_oe(rst_n), .rom_image(img_a),
    .dout(d0), .dout_en(e0), .ce_out_n(co0));

  serial_cfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0)) dut2 (
    .clk(clk), .ce_n(co0), .rst_oe(rst_n), .rom_image(img_b),
    .dout(d1), .dout_en(e1), .ce_out_n(co1));

  serial_cfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1)) dut_h (
    .clk(clk), .ce_n(ce0_n), .rst_oe(rst_h), .rom_image(img_a),
    .dout(dh), .dout_en(eh), .ce_out_n(coh));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_clk();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  task automatic do_reset(input logic [D-1:0] a, input logic [D-1:0] b);
    @(negedge clk);
    rst_n = 1'b0; ce0_n = 1'b0; img_a = a; img_b = b;
    step_clk();
    chk(!e0 && !e1 && co0 && co1, "R1 reset state", {e0, e1, co0, co1}, 4'b0011);
    chk(!eh && coh, "R2 active-high instance idle when its pin is high", {eh, coh}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
  endtask

  task automatic run_stream(input logic [D-1:0] a, input logic [D-1:0] b);
    logic m;
    do_reset(a, b);
    for (int k = 0; k < 2 * D; k++) begin
      m = e0 ? d0 : (e1 ? d1 : 1'b0);
      chk(int'(e0) + int'(e1) == 1, "R9 single driver", int'(e0) + int'(e1), 1);
      chk(m == ((k < D) ? a[k] : b[k - D]), "R3/R9 stream bit", m, (k < D) ? a[k] : b[k - D]);
      chk(dh == d0 && eh == e0, "R2 polarity twins agree", {dh, eh}, {d0, e0});
      step_clk();
    end
    chk(!e0 && !e1 && !co0 && !co1, "R6 both exhausted", {e0, e1, co0, co1}, 0);
    repeat (3) step_clk();
    chk(!e0 && !e1 && !co0, "R6 no wrap after extra edges", {e0, e1, co0}, 0);
    ce0_n = 1'b1; #0.5;
    chk(co0 && co1 && !e1, "R7 cascade follows chip enable high", {co0, co1, e1}, 3'b110);
    ce0_n = 1'b0; #0.5;
    chk(!co0 && !e0, "R7 cascade follows chip enable low", {co0, e0}, 0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    run_stream(16'hA5C3, 16'h0F1E);
    run_stream('1, '0);
    run_stream('0, '1);
    for (int i = 0; i < D; i++) run_stream(D'(1) << i, ~(D'(1) << i));

    do_reset(16'h3C96, 16'h0);
    for (int k = 0; k < 5; k++) step_clk();
    ce0_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #0.5;
      chk(!e0 && !e1, "R4 standby floats data", {e0, e1}, 0);
      step_clk();
    end
    ce0_n = 1'b0; #0.5;
    chk(e0 && d0 == img_a[5], "R4 resumes at next unread bit", d0, img_a[5]);
    chk(e0 && !e1 && co0, "R5 only first device drives", {e0, e1, co0}, 3'b101);

    @(negedge clk); rst_n = 1'b0; #0.5;
    chk(!e0 && co0, "R1 mid-stream reset", {e0, co0}, 2'b01);
    @(negedge clk); rst_n = 1'b1; #0.5;
    chk(e0 && d0 == img_a[0], "R1 restart at bit 0", d0, img_a[0]);

    for (int k = 0; k < D; k++) step_clk();
    chk(!co0 && !e0, "R6 first device past end", {co0, e0}, 0);
    @(negedge clk); rst_n = 1'b0; #0.5;
    chk(co0 && coh, "R8 cascade high under reset", {co0, coh}, 2'b11);
    @(negedge clk); rst_n = 1'b1; #0.5;
    chk(co0 && e0 && d0 == img_a[0], "R8 flag cleared by reset", {co0, e0}, 2'b11);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule